// File: doc/BRIEF.md
# Hysteretic Half-Bridge Gate Sequencer

This block turns a single synchronized comparator bit into the two gate-enable outputs of a buck half bridge. The comparator bit `fb_above` says whether the sensed load current is above the regulation threshold. While the current is below the threshold, the high-side enable `ho` is on. While it is above, the low-side enable `lo` is on. The loop runs freely, so the comparator sets the switching rate and no period timer is used. It must keep up with switching up to 500 kHz. Every change of direction waits through a configurable comparator-to-output delay, which also rejects short comparator glitches. A dead band of `DEAD_CYC` cycles with both outputs low always lies between one output falling and the other rising.

A watchdog guards long high-side conduction, for example when the load is open and the current never reaches the threshold. If `ho` stays on for `WD_LIMIT` cycles in a row, the block opens a dead band and drives `lo` for `REFRESH_CYC` cycles so the bootstrap capacitor can recharge. It then goes back to regulating. A supervisor enable `run_en` parks the sequencer in an idle state with both outputs low, so the supervisor decides how the switches are held.

The states are:

- `ST_IDLE`: both outputs low.
- `ST_HI_ON`: high side conducting.
- `ST_HI_EXIT`: high side still on while the turn-off delay runs.
- `ST_GAP_HL`: dead band before the low side.
- `ST_LO_ON`: low side conducting.
- `ST_LO_EXIT`: low side still on while its turn-off delay runs.
- `ST_GAP_LH`: dead band before the high side.
- `ST_WD_GAP`: dead band opened by the watchdog.
- `ST_WD_REFRESH`: forced low-side refresh pulse.

The transitions are:

- `ST_IDLE` goes to `ST_LO_ON` when `run_en` is high.
- `ST_HI_ON` goes to `ST_HI_EXIT` when `fb_above` is sampled high.
- `ST_HI_EXIT` goes back to `ST_HI_ON` if `fb_above` is sampled low before the delay ends.
- `ST_HI_EXIT` goes to `ST_GAP_HL` when the delay ends.
- `ST_GAP_HL` goes to `ST_LO_ON` after the dead band.
- `ST_LO_ON` goes to `ST_LO_EXIT` when `fb_above` is sampled low.
- `ST_LO_EXIT` goes back to `ST_LO_ON` if `fb_above` is sampled high before the delay ends.
- `ST_LO_EXIT` goes to `ST_GAP_LH` when the delay ends.
- `ST_GAP_LH` goes to `ST_HI_ON` after the dead band.
- `ST_HI_ON` or `ST_HI_EXIT` goes to `ST_WD_GAP` when the watchdog expires.
- `ST_WD_GAP` goes to `ST_WD_REFRESH` after the dead band.
- `ST_WD_REFRESH` goes to `ST_GAP_LH`, or to `ST_LO_ON` if `fb_above` is high when the refresh pulse ends.
- Any state goes to `ST_IDLE` when `run_en` is low.

Top module: `hb_gate_seq`

## Requirements
- R1: While `rst_n` is low, and after reset for as long as `run_en` stays low, `ho` = 0 and `lo` = 0.
- R2: Whenever `run_en` is sampled low, both outputs are 0 from the next cycle on, and `fb_above` has no effect on them. The first rising edge that samples `run_en` high drives `lo` = 1 and `ho` = 0.
- R3: `ho` and `lo` are never 1 in the same cycle.
- R4: Suppose `ho` is on and `fb_above` = 1 is sampled at rising edge k. Then `ho` falls at edge k+`HO_OFF_DLY` (default 18) and `lo` rises at edge k+`HO_OFF_DLY`+`DEAD_CYC` (default 14).
- R5: Suppose `lo` is on and `fb_above` = 0 is sampled at edge k. Then `lo` falls at edge k+`LO_OFF_DLY` (default 18) and `ho` rises at edge k+`LO_OFF_DLY`+`DEAD_CYC`.
- R6: If `fb_above` returns to its previous level before the turn-off delay of R4 or R5 has run out, the conducting output stays on and the other output stays off.
- R7: After `ho` has been 1 for `WD_LIMIT` consecutive cycles (default 2000), it falls. `lo` rises `DEAD_CYC` cycles later and stays 1 for `REFRESH_CYC` cycles (default 100). If `fb_above` is still 0, `ho` rises again `DEAD_CYC` cycles after `lo` falls.
- R8: During the watchdog dead band and refresh pulse, `fb_above` is ignored. If it is 1 when the pulse ends, `lo` stays on and `ho` stays off.
- R9: The watchdog count restarts whenever `ho` is 0, so every new high-side period may last the full `WD_LIMIT` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Supervisor enable; low parks the sequencer idle |
| fb_above | input | 1 | Synchronized comparator bit, 1 when the load current is above the threshold |
| ho | output | 1 | High-side gate enable |
| lo | output | 1 | Low-side gate enable |

## Verification
The outputs are decoded straight from the state register. A change sampled at rising edge k therefore appears after edge k+D, where D is the turn-off delay, the delay plus the dead band, the watchdog limit, or the refresh length. The only exception is the enable response, which appears after a single edge. The bench drives inputs on falling edges, so the next rising edge is edge k. It then counts exactly D rising edges and samples on the falling edge that follows. It checks one cycle before each edge as well, so a result that arrives early or late is caught. In the random phase every comparator level is held longer than the longest delay plus dead band, and the settled outputs are compared with the level the requirements predict.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HI_ON,
        ST_HI_EXIT,
        ST_GAP_HL,
        ST_LO_ON,
        ST_LO_EXIT,
        ST_GAP_LH,
        ST_WD_GAP,
        ST_WD_REFRESH
    } seq_state_t;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/hb_phase_timer.sv
module hb_phase_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] count
);
    // Cycles spent in the current state; saturates instead of wrapping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (restart)
            count <= '0;
        else if (count != {CW{1'b1}})
            count <= count + 1'b1;
    end
endmodule

// File: rtl/hb_hi_watchdog.sv
module hb_hi_watchdog #(
    parameter int unsigned LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_active,
    output logic expired
);
    localparam int unsigned WW = $clog2(LIMIT + 1);
    localparam logic [WW-1:0] LAST = WW'(LIMIT - 1);

    logic [WW-1:0] run_cnt;

    assign expired = hi_active && (run_cnt == LAST);

    // Counts consecutive high-side cycles; any low cycle clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (!hi_active)
            run_cnt <= '0;
        else if (!expired)
            run_cnt <= run_cnt + 1'b1;
    end
endmodule

// File: rtl/hb_seq_fsm.sv
module hb_seq_fsm
    import hb_gate_pkg::*;
#(
    parameter int unsigned HO_OFF_DLY  = 18,
    parameter int unsigned LO_OFF_DLY  = 18,
    parameter int unsigned DEAD_CYC    = 14,
    parameter int unsigned REFRESH_CYC = 100,
    parameter int unsigned CW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          fb_above,
    input  logic [CW-1:0] phase_cnt,
    input  logic          wd_expired,
    output logic          restart,
    output logic          ho,
    output logic          lo
);
    localparam logic [CW-1:0] LAST_HO_DLY = CW'(HO_OFF_DLY - 1);
    localparam logic [CW-1:0] LAST_LO_DLY = CW'(LO_OFF_DLY - 1);
    localparam logic [CW-1:0] LAST_DEAD   = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] LAST_REFR   = CW'(REFRESH_CYC - 1);

    seq_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (!run_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_LO_ON;
                ST_HI_ON: begin
                    if (wd_expired)            state_d = ST_WD_GAP;
                    else if (fb_above)         state_d = ST_HI_EXIT;
                end
                ST_HI_EXIT: begin
                    if (wd_expired)            state_d = ST_WD_GAP;
                    else if (!fb_above)        state_d = ST_HI_ON;
                    else if (phase_cnt == LAST_HO_DLY) state_d = ST_GAP_HL;
                end
                ST_GAP_HL: begin
                    if (phase_cnt == LAST_DEAD) state_d = ST_LO_ON;
                end
                ST_LO_ON: begin
                    if (!fb_above)             state_d = ST_LO_EXIT;
                end
                ST_LO_EXIT: begin
                    if (fb_above)              state_d = ST_LO_ON;
                    else if (phase_cnt == LAST_LO_DLY) state_d = ST_GAP_LH;
                end
                ST_GAP_LH: begin
                    if (phase_cnt == LAST_DEAD) state_d = ST_HI_ON;
                end
                ST_WD_GAP: begin
                    if (phase_cnt == LAST_DEAD) state_d = ST_WD_REFRESH;
                end
                ST_WD_REFRESH: begin
                    if (phase_cnt == LAST_REFR)
                        state_d = fb_above ? ST_LO_ON : ST_GAP_LH;
                end
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    assign restart = (state_d != state_q);

    // Output decode
    always_comb begin
        ho = 1'b0;
        lo = 1'b0;
        unique case (state_q)
            ST_HI_ON, ST_HI_EXIT:                 ho = 1'b1;
            ST_LO_ON, ST_LO_EXIT, ST_WD_REFRESH:  lo = 1'b1;
            ST_IDLE, ST_GAP_HL, ST_GAP_LH,
            ST_WD_GAP:                            ;
            default:                              ;
        endcase
    end
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
    import hb_gate_pkg::*;
#(
    parameter int unsigned HO_OFF_DLY  = 18,
    parameter int unsigned LO_OFF_DLY  = 18,
    parameter int unsigned DEAD_CYC    = 14,
    parameter int unsigned WD_LIMIT    = 2000,
    parameter int unsigned REFRESH_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic fb_above,
    output logic ho,
    output logic lo
);
    localparam int unsigned MAX_PHASE = max4(HO_OFF_DLY, LO_OFF_DLY, DEAD_CYC, REFRESH_CYC);
    localparam int unsigned CW        = $clog2(MAX_PHASE + 1);

    logic          restart;
    logic [CW-1:0] phase_cnt;
    logic          wd_expired;

    hb_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .count   (phase_cnt)
    );

    hb_hi_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_active (ho),
        .expired   (wd_expired)
    );

    hb_seq_fsm #(
        .HO_OFF_DLY  (HO_OFF_DLY),
        .LO_OFF_DLY  (LO_OFF_DLY),
        .DEAD_CYC    (DEAD_CYC),
        .REFRESH_CYC (REFRESH_CYC),
        .CW          (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .fb_above   (fb_above),
        .phase_cnt  (phase_cnt),
        .wd_expired (wd_expired),
        .restart    (restart),
        .ho         (ho),
        .lo         (lo)
    );
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk #(
    parameter int unsigned WD_LIMIT = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic ho,
    input logic lo
);
    localparam int unsigned HW = $clog2(WD_LIMIT + 2);

    logic [HW-1:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_run <= '0;
        else if (!ho)
            hi_run <= '0;
        else if (hi_run != {HW{1'b1}})
            hi_run <= hi_run + 1'b1;
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ho && lo)); // R3

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!ho && !lo)); // R2

    AST_HO_FALL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ho) |-> !lo); // R4

    AST_HO_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ho) |-> !$past(lo)); // R5

    AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ho |-> (hi_run < HW'(WD_LIMIT))); // R7
endmodule

bind hb_gate_seq hb_gate_seq_chk #(.WD_LIMIT(WD_LIMIT)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .ho     (ho),
    .lo     (lo)
);

// File: tb/hb_gate_seq_tb.sv
module hb_gate_seq_tb;
    localparam int HOD  = 18;
    localparam int LOD  = 18;
    localparam int DT   = 14;
    localparam int WD   = 2000;
    localparam int REF  = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic fb_above = 1'b1;
    logic ho, lo;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hb_gate_seq u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .fb_above (fb_above),
        .ho       (ho),
        .lo       (lo)
    );

    // Expected {ho,lo} once a comparator level has settled in regulation
    function automatic logic [1:0] settled(logic fb);
        return fb ? 2'b01 : 2'b10;
    endfunction

    task automatic check(string tag, logic [1:0] exp);
        n_chk++;
        if ({ho, lo} !== exp) begin
            n_err++;
            $display("FAIL %s: {ho,lo} actual=%b expected=%b at %0t", tag, {ho, lo}, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // R3 monitor: both enables never high together
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (ho && lo) begin
                n_err++;
                $display("FAIL R3: {ho,lo} actual=11 expected=not 11 at %0t", $time);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        step(3);
        check("R1 in reset", 2'b00);
        rst_n = 1'b1;
        step(4);
        check("R1 after reset, run_en low", 2'b00);

        // R2 start-up
        run_en = 1'b1;
        step(1);
        check("R2 enable drives lo", 2'b01);

        // R5 low-side turn-off then dead band
        fb_above = 1'b0;
        step(LOD);
        check("R5 lo still on before delay", 2'b01);
        step(1);
        check("R5 lo off after delay", 2'b00);
        step(DT - 1);
        check("R5 dead band held", 2'b00);
        step(1);
        check("R5 ho on after dead band", 2'b10);

        // R6 high-side glitch rejection
        fb_above = 1'b1;
        step(5);
        fb_above = 1'b0;
        step(30);
        check("R6 ho kept through short glitch", 2'b10);

        // R4 high-side turn-off then dead band
        fb_above = 1'b1;
        step(HOD);
        check("R4 ho still on before delay", 2'b10);
        step(1);
        check("R4 ho off after delay", 2'b00);
        step(DT - 1);
        check("R4 dead band held", 2'b00);
        step(1);
        check("R4 lo on after dead band", 2'b01);

        // R6 low-side glitch rejection
        fb_above = 1'b0;
        step(5);
        fb_above = 1'b1;
        step(30);
        check("R6 lo kept through short glitch", 2'b01);

        // R7 watchdog refresh with the comparator stuck low
        fb_above = 1'b0;
        step(LOD + 1 + DT);
        check("R7 ho on", 2'b10);
        step(WD - 1);
        check("R7 ho still on at limit-1", 2'b10);
        step(1);
        check("R7 ho forced off", 2'b00);
        step(DT - 1);
        check("R7 gap before refresh", 2'b00);
        step(1);
        check("R7 refresh pulse starts", 2'b01);
        step(REF - 1);
        check("R7 refresh pulse last cycle", 2'b01);
        step(1);
        check("R7 refresh pulse ends", 2'b00);
        step(DT);
        check("R7 ho back on", 2'b10);

        // R9 full period after the refresh
        step(WD - 1);
        check("R9 fresh period lasts full limit", 2'b10);
        step(1);
        check("R9 second watchdog fires", 2'b00);

        // R8 comparator change during the refresh is ignored, lo kept at end
        fb_above = 1'b1;
        step(DT);
        check("R8 refresh starts despite fb", 2'b01);
        step(REF);
        check("R8 lo held after refresh", 2'b01);
        step(40);
        check("R8 stays low side", 2'b01);

        // R2 disable and ignore comparator
        run_en = 1'b0;
        step(1);
        check("R2 disable clears outputs", 2'b00);
        fb_above = 1'b0;
        step(60);
        check("R2 fb ignored while disabled", 2'b00);
        run_en = 1'b1;
        step(1);
        check("R2 re-enable drives lo", 2'b01);
        fb_above = 1'b1;
        step(40);
        check("R4 settled low side", 2'b01);

        // Random regulation phase (R4, R5)
        for (int i = 0; i < 300; i++) begin
            logic lvl;
            int hold;
            lvl = logic'($urandom_range(1, 0));
            hold = int'($urandom_range(300, 40));
            fb_above = lvl;
            step(hold);
            check(lvl ? "R4 random settle" : "R5 random settle", settled(lvl));
        end

        finish_run();
    end
endmodule